// File: doc/BRIEF.md
# Read Completion Splitter

This block turns one accepted memory read request into the ordered list of completions that answer it. A request carries a start address, a byte length, a requester tag and a requester ID. The block emits one completion descriptor per handshake. Each descriptor holds the address of its chunk, the chunk's byte count, the bytes still owed before that chunk, a final-chunk flag, and the tag and ID of the request.

Split points fall only on naturally aligned read completion boundaries. The boundary is 64 or 128 bytes, chosen by a one-bit configuration input. An endpoint ties this input to 128. Chunk size is capped by a maximum payload given as a 3-bit register code. A read that starts off a boundary gets a shortened first chunk that ends on the next boundary. After that the chunks run at the full payload size until the request is used up.

Requests enter through a valid/ready handshake. Descriptors leave through a second valid/ready handshake and are held steady under backpressure. A new request is taken only once the last descriptor of the current one has been consumed. The configuration is captured when a request is accepted.

Top module: `rcpl_splitter`

## Requirements
- R1: After reset `req_ready` is 1 and `out_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `out_valid` is 1 from the next cycle onward. `req_ready` stays 0 until the edge that consumes the final descriptor, and it is 1 again in the cycle after that edge.
- R3: `cfg_rcb_128` = 0 selects a 64-byte boundary and 1 selects a 128-byte boundary. Every non-final chunk ends on an address that is a multiple of the selected boundary.
- R4: Maximum payload code `cfg_mps_code`: 0=128, 1=256, 2=512, 3=1024, 4=2048, 5=4096 bytes. Codes 6 and 7 act as 128.
- R5: When the chunk address is a multiple of the boundary, the chunk size is the smaller of the remaining bytes and the maximum payload. A 512-byte aligned read with a 256-byte payload gives exactly two chunks.
- R6: When the chunk address is not a multiple of the boundary, the chunk size is the smaller of the remaining bytes and the distance to the next boundary.
- R7: `out_remain` is the byte count still owed before the chunk is sent, and it equals the request length on the first descriptor. Each following descriptor's address and remaining count move forward by the previous byte count.
- R8: `out_last` is 1 only on the final descriptor, and there `out_bytes` equals `out_remain`.
- R9: A zero-length request yields exactly one descriptor with `out_bytes` = 0, `out_remain` = 0 and `out_last` = 1.
- R10: While `out_valid` is 1 and `out_ready` is 0, the descriptor stays valid and all of its fields stay unchanged.
- R11: Every descriptor of a request carries that request's tag and requester ID.
- R12: `cfg_rcb_128`, `cfg_mps_code` and the request inputs are sampled only at acceptance. Changing them while a request is in progress does not alter its descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address of the read |
| req_len | input | LEN_W | Read length in bytes |
| req_tag | input | TAG_W | Requester tag |
| req_rid | input | RID_W | Requester ID |
| cfg_rcb_128 | input | 1 | Boundary select: 0 = 64 bytes, 1 = 128 bytes |
| cfg_mps_code | input | 3 | Maximum payload code |
| out_valid | output | 1 | Descriptor present |
| out_ready | input | 1 | Consumer takes the descriptor |
| out_addr | output | ADDR_W | Chunk start address |
| out_bytes | output | LEN_W | Chunk byte count |
| out_remain | output | LEN_W | Bytes owed before this chunk |
| out_last | output | 1 | Final chunk of the request |
| out_tag | output | TAG_W | Tag of the request |
| out_rid | output | RID_W | Requester ID of the request |

## Verification
The first descriptor is due one cycle after the accepting edge. Each later descriptor is due one cycle after the edge that consumed the one before it. `req_ready` returns one cycle after the final consume. All descriptor fields come straight from registers, so they settle right after the rising edge and do not depend on `out_ready`. The bench changes every input on the falling edge, reads the outputs shortly after it, and compares each cycle's descriptor with a chunk computed in the bench from the address, the remaining count and the captured settings. A stalled cycle therefore has to show the same expected descriptor again.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

  // Maximum payload register codes
  typedef enum logic [2:0] {
    MPS_128  = 3'd0,
    MPS_256  = 3'd1,
    MPS_512  = 3'd2,
    MPS_1K   = 3'd3,
    MPS_2K   = 3'd4,
    MPS_4K   = 3'd5
  } mps_code_e;

  localparam int RCB_SMALL_LOG2 = 6;
  localparam int RCB_LARGE_LOG2 = 7;
  localparam int MPS_MAX_LOG2   = 12;

  // log2 of the payload cap; reserved codes fall back to 128 bytes
  function automatic logic [3:0] mps_log2(input logic [2:0] code);
    logic [3:0] r;
    case (code)
      MPS_128: r = 4'd7;
      MPS_256: r = 4'd8;
      MPS_512: r = 4'd9;
      MPS_1K:  r = 4'd10;
      MPS_2K:  r = 4'd11;
      MPS_4K:  r = 4'd12;
      default: r = 4'd7;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rcs_cfg_decode.sv
module rcs_cfg_decode #(
  parameter int LEN_W = 13
) (
  input  logic             rcb_128,
  input  logic [2:0]       mps_code,
  output logic [LEN_W-1:0] rcb_bytes,
  output logic [LEN_W-1:0] mps_bytes
);
  import rcs_pkg::*;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  always_comb begin
    rcb_bytes = rcb_128 ? (ONE << RCB_LARGE_LOG2) : (ONE << RCB_SMALL_LOG2);
    mps_bytes = ONE << mps_log2(mps_code);
  end

endmodule

// File: rtl/rcs_chunk_calc.sv
module rcs_chunk_calc #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  remain,
  input  logic [LEN_W-1:0]  rcb_bytes,
  input  logic [LEN_W-1:0]  mps_bytes,
  output logic [LEN_W-1:0]  chunk,
  output logic              is_last,
  output logic              unaligned
);

  localparam int OFF_W = 7;

  // offset of the address inside its boundary window
  function automatic logic [LEN_W-1:0] bound_offset(
    input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] rcb);
    logic [LEN_W-1:0] low;
    low = {{(LEN_W-OFF_W){1'b0}}, a[OFF_W-1:0]};
    return low & (rcb - LEN_W'(1));
  endfunction

  // longest legal chunk before the request length is applied
  function automatic logic [LEN_W-1:0] chunk_limit(
    input logic [LEN_W-1:0] off, input logic [LEN_W-1:0] rcb,
    input logic [LEN_W-1:0] mps);
    return (off != '0) ? (rcb - off) : mps;
  endfunction

  logic [LEN_W-1:0] off;
  logic [LEN_W-1:0] lim;

  always_comb begin
    off       = bound_offset(cur_addr, rcb_bytes);
    lim       = chunk_limit(off, rcb_bytes, mps_bytes);
    unaligned = (off != '0);
    is_last   = (remain <= lim);
    chunk     = is_last ? remain : lim;
  end

endmodule

// File: rtl/rcs_cursor.sv
module rcs_cursor #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13,
  parameter int TAG_W  = 8,
  parameter int RID_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [RID_W-1:0]  ld_rid,
  input  logic [LEN_W-1:0]  ld_rcb,
  input  logic [LEN_W-1:0]  ld_mps,
  input  logic              step,
  input  logic [LEN_W-1:0]  chunk,
  input  logic              is_last,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  remain,
  output logic [TAG_W-1:0]  tag_q,
  output logic [RID_W-1:0]  rid_q,
  output logic [LEN_W-1:0]  rcb_q,
  output logic [LEN_W-1:0]  mps_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
      tag_q    <= '0;
      rid_q    <= '0;
      rcb_q    <= '0;
      mps_q    <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      cur_addr <= ld_addr;
      remain   <= ld_len;
      tag_q    <= ld_tag;
      rid_q    <= ld_rid;
      rcb_q    <= ld_rcb;
      mps_q    <= ld_mps;
    end else if (step) begin
      cur_addr <= cur_addr + ADDR_W'(chunk);
      remain   <= remain - chunk;
      if (is_last) busy <= 1'b0;
    end
  end

endmodule

// File: rtl/rcpl_splitter.sv
module rcpl_splitter #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13,
  parameter int TAG_W  = 8,
  parameter int RID_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [RID_W-1:0]  req_rid,
  input  logic              cfg_rcb_128,
  input  logic [2:0]        cfg_mps_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LEN_W-1:0]  out_bytes,
  output logic [LEN_W-1:0]  out_remain,
  output logic              out_last,
  output logic [TAG_W-1:0]  out_tag,
  output logic [RID_W-1:0]  out_rid
);

  // named internal events, also used by the checker
  logic             busy;
  logic             req_fire;
  logic             desc_fire;
  logic             done_evt;
  logic             first_unaligned;
  logic [LEN_W-1:0] rcb_in, mps_in, rcb_q, mps_q;
  logic [LEN_W-1:0] chunk, remain;
  logic             is_last;
  logic [ADDR_W-1:0] cur_addr;

  assign req_ready = !busy;
  assign req_fire  = req_valid && req_ready;
  assign out_valid = busy;
  assign desc_fire = out_valid && out_ready;
  assign done_evt  = desc_fire && is_last;

  rcs_cfg_decode #(.LEN_W(LEN_W)) u_cfg (
    .rcb_128   (cfg_rcb_128),
    .mps_code  (cfg_mps_code),
    .rcb_bytes (rcb_in),
    .mps_bytes (mps_in)
  );

  rcs_cursor #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .RID_W(RID_W)) u_cur (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (req_fire),
    .ld_addr  (req_addr),
    .ld_len   (req_len),
    .ld_tag   (req_tag),
    .ld_rid   (req_rid),
    .ld_rcb   (rcb_in),
    .ld_mps   (mps_in),
    .step     (desc_fire),
    .chunk    (chunk),
    .is_last  (is_last),
    .busy     (busy),
    .cur_addr (cur_addr),
    .remain   (remain),
    .tag_q    (out_tag),
    .rid_q    (out_rid),
    .rcb_q    (rcb_q),
    .mps_q    (mps_q)
  );

  rcs_chunk_calc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_calc (
    .cur_addr  (cur_addr),
    .remain    (remain),
    .rcb_bytes (rcb_q),
    .mps_bytes (mps_q),
    .chunk     (chunk),
    .is_last   (is_last),
    .unaligned (first_unaligned)
  );

  assign out_addr   = cur_addr;
  assign out_bytes  = chunk;
  assign out_remain = remain;
  assign out_last   = is_last;

endmodule

// File: rtl/rcs_checker.sv
module rcs_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 13,
  parameter int TAG_W  = 8,
  parameter int RID_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [LEN_W-1:0]  out_bytes,
  input logic [LEN_W-1:0]  out_remain,
  input logic              out_last,
  input logic [TAG_W-1:0]  out_tag,
  input logic [RID_W-1:0]  out_rid,
  input logic              desc_fire,
  input logic              done_evt
);

  assert_first_desc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (out_valid && !req_ready));

  assert_idle_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (req_ready && !out_valid));

  assert_split_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> ((out_addr[5:0] + out_bytes[5:0]) == 6'd0));

  assert_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bytes <= LEN_W'(4096)));

  assert_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_fire && !out_last) |=> (out_valid
      && out_remain == $past(out_remain) - $past(out_bytes)
      && out_addr == $past(out_addr) + ADDR_W'($past(out_bytes))));

  assert_last_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (out_bytes == out_remain));

  assert_not_last_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (out_bytes < out_remain && out_bytes != '0));

  assert_zero_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_remain == '0) |-> (out_last && out_bytes == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
      && $stable(out_bytes) && $stable(out_remain) && $stable(out_last)));

  assert_ids_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_fire && !out_last) |=> ($stable(out_tag) && $stable(out_rid)));

endmodule

bind rcpl_splitter rcs_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .RID_W(RID_W)
) u_rcs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_bytes  (out_bytes),
  .out_remain (out_remain),
  .out_last   (out_last),
  .out_tag    (out_tag),
  .out_rid    (out_rid),
  .desc_fire  (desc_fire),
  .done_evt   (done_evt)
);

// File: tb/test_rcpl_splitter.sv
module test_rcpl_splitter;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 13;
  localparam int TAG_W  = 8;
  localparam int RID_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0]  req_len = '0;
  logic [TAG_W-1:0]  req_tag = '0;
  logic [RID_W-1:0]  req_rid = '0;
  logic              cfg_rcb_128 = 1'b1;
  logic [2:0]        cfg_mps_code = 3'd0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [ADDR_W-1:0] out_addr;
  logic [LEN_W-1:0]  out_bytes;
  logic [LEN_W-1:0]  out_remain;
  logic              out_last;
  logic [TAG_W-1:0]  out_tag;
  logic [RID_W-1:0]  out_rid;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rcpl_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .RID_W(RID_W)) i_rcpl_splitter (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_len, .req_tag, .req_rid,
    .cfg_rcb_128, .cfg_mps_code, .out_valid, .out_ready, .out_addr, .out_bytes,
    .out_remain, .out_last, .out_tag, .out_rid
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // payload cap in bytes, stated per code (R4)
  function automatic int cap_of(input int code);
    if (code > 5) return 128;
    return 128 * (2 ** code);
  endfunction

  // expected chunk by the requirement wording (R5, R6)
  function automatic int exp_chunk(input longint a, input int rem, input bit big, input int code);
    int b = big ? 128 : 64;
    int m = (a % b == 0) ? cap_of(code) : (b - int'(a % b));
    return (rem < m) ? rem : m;
  endfunction

  task automatic run_req(input longint a, input int len, input bit big, input int code,
                         input int ready_pct, input string note);
    longint ea = a;
    int er = len;
    int n = 0;
    bit done = 0;
    logic [TAG_W-1:0] t = TAG_W'($urandom);
    logic [RID_W-1:0] r = RID_W'($urandom);
    @(negedge clk);
    req_valid = 1'b1; req_addr = ADDR_W'(a); req_len = LEN_W'(len);
    req_tag = t; req_rid = r; cfg_rcb_128 = big; cfg_mps_code = 3'(code);
    #1;
    chk(req_ready == 1'b1, "R2 ready before accept", req_ready, 1);
    @(negedge clk);
    // scramble everything sampled only at acceptance (R12)
    req_valid = 1'b0; req_addr = ADDR_W'($urandom); req_len = LEN_W'($urandom);
    req_tag = TAG_W'($urandom); req_rid = RID_W'($urandom);
    cfg_rcb_128 = ~big; cfg_mps_code = 3'($urandom);
    #1;
    chk(req_ready == 1'b0, "R2 busy after accept", req_ready, 0);
    while (!done) begin
      int eb;
      bit el;
      out_ready = (($urandom % 100) < ready_pct);
      #1;
      eb = exp_chunk(ea, er, big, code);
      el = (eb == er);
      chk(out_valid == 1'b1, "R2 descriptor valid", out_valid, 1);
      chk(longint'(out_addr) == (ea & 64'hFFFF_FFFF), out_ready ? "R7 addr" : "R10 addr held", out_addr, ea);
      chk(int'(out_bytes) == eb, (ea % (big ? 128 : 64) != 0) ? "R6 bytes unaligned" : "R5 bytes aligned", out_bytes, eb);
      chk(int'(out_remain) == er, "R7 remain", out_remain, er);
      chk(out_last == el, "R8 last flag", out_last, el);
      chk(out_tag == t && out_rid == r, "R11 tag/id", {out_tag, out_rid}, {t, r});
      if (out_ready) begin
        ea = ea + eb; er = er - eb; n++;
        if (el) done = 1;
      end
      @(negedge clk);
      #1;
    end
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && req_ready == 1'b1, "R2 idle after last", {out_valid, req_ready}, 2'b01);
    if (len == 0) chk(n == 1, "R9 single descriptor", n, 1);
    if (note == "two") chk(n == 2, "R5 512 in 256 chunks", n, 2);
    if (note == "resv") chk(n == 4, "R4 reserved code count", n, 4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    #1;
    chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
    chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1 && out_valid == 1'b0, "R1 after reset", {req_ready, out_valid}, 2'b10);
    run_req(64'h1000, 512, 1'b1, 1, 100, "two");
    run_req(64'h1040, 300, 1'b1, 2, 70, "R6 off128");
    run_req(64'h0010, 300, 1'b0, 2, 50, "R3 rcb64");
    run_req(64'h0030, 10, 1'b0, 0, 100, "short");
    run_req(64'h2000, 0, 1'b1, 3, 60, "zero");
    run_req(64'h2004, 0, 1'b0, 5, 100, "zero");
    run_req(64'h3000, 512, 1'b1, 7, 80, "resv");
    run_req(64'h3000, 512, 1'b1, 6, 40, "resv");
    run_req(64'h4000, 4096, 1'b1, 5, 100, "max");
    run_req(64'hFFFF_FFC0, 64, 1'b0, 0, 30, "top");
    for (int i = 0; i < 60; i++) begin
      longint a = longint'($urandom);
      int len = int'($urandom % 4097);
      run_req(a, len, 1'($urandom), int'($urandom % 8), 20 + int'($urandom % 81), "rand");
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule